// File: doc/BRIEF.md
# Multi-Function Timer Bank with Dual Compare

This block holds a bank of independent 16-bit up-counting timers behind a small word-wide register port. Every timer owns a counter, two compare registers and a setup register. The counter is clocked by a slow reference strobe (`ref_tick`, one system clock wide) through a power-of-two prescaler.

When the count reaches a compare value, the timer latches a sticky flag. Software acknowledges a flag by writing a one to it. The second compare channel also bounds the count period: the counter returns to zero on the prescaled tick after it reaches compare-2. A per-timer event output follows the compare-2 flag when the compare-2 event mode is armed. Steering that output to an interrupt or to a non-maskable request is left to logic outside the block.

The configuration fields (the prescale exponent and the compare-2 event mode) can be written once after reset. The first write to a timer's setup register also sets a "configured" status bit. From then on, writes to setup can only start or stop the count and acknowledge flags.

Top module: `mft_bank`

## Requirements
- R1: After reset every compare, counter and setup register reads 0, and every `evt_out` bit is low.
- R2: Timer i decodes byte addresses i*8 to i*8+7. Within that window, offset 0 is compare-1, offset 2 is compare-2, offset 4 is the counter and offset 6 is setup. Address bit 0 is ignored. `rdata` presents the addressed word on the clock after `rd_en`.
- R3: An address at or above N_TIMERS*8 reads as 0, and a write to it changes no register.
- R4: The setup word uses these fields: [3:0] prescale exponent, [9:8] compare-2 event mode, [12] configured status (read only), [13] compare-1 flag, [14] compare-2 flag, [15] count enable. All other bits read 0.
- R5: While enabled, the counter takes one step every 2^min(exponent,8) `ref_tick` strobes, so divisors from 1 to 256 are available. Exponents above 8 divide by 256. The prescaler restarts from zero while the count is disabled and on every counter write.
- R6: The counter changes only on a prescaled tick while count enable is 1, or on a register write. With enable 0 it holds its value whatever `ref_tick` does.
- R7: When a tick moves the counter onto the compare-2 value, the compare-2 flag sets. The next tick loads 0 into the counter.
- R8: When a tick moves the counter onto the compare-1 value, the compare-1 flag sets. This affects neither the count sequence nor `evt_out`.
- R9: `evt_out[i]` is high exactly while timer i's compare-2 flag is set and its event mode is 3 (binary 11). With any other mode it stays low.
- R10: Writing 1 to a flag bit of setup clears that flag, and writing 0 leaves it as it is. A flag set by hardware in the same cycle as a clear stays set. One write with both flag bits 1 and enable 0 stops the timer and clears both flags.
- R11: The first setup write after reset loads the exponent and mode and sets the configured bit. Later setup writes leave the exponent and mode unchanged until reset.
- R12: A counter write loads the written value, 0 included, and sets no flag by itself.
- R13: Stepping from 0xFFFF goes to 0 when compare-2 has not been reached, and that step can set the compare-1 flag when compare-1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe of the slow reference clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered, valid the cycle after `rd_en` |
| evt_out | output | N_TIMERS | Per-timer compare-2 event outputs |

## Verification
The bench builds the block with four timers and a 6-bit address. The top half of the address space therefore falls outside the window, which exercises miss decode and aliasing. With the reference strobe single-stepped by hand, the bench can check the counter value after every tick, including the compare-1 and compare-2 hits, the wrap and the 0xFFFF rollover. Every prescale exponent from 0 to 9 is swept with the strobe held high, and each time to the first compare-2 event is compared against 3 * 2^min(exponent,8) cycles. This covers the full divisor range and the clamp above it.

// File: rtl/mft_pkg.sv
package mft_pkg;

  // setup word field positions
  localparam int SCALE_LSB = 0;
  localparam int SCALE_W   = 4;
  localparam int MODE_LSB  = 8;
  localparam int MODE_W    = 2;
  localparam int DONE_BIT  = 12;
  localparam int F1_BIT    = 13;
  localparam int F2_BIT    = 14;
  localparam int EN_BIT    = 15;

  localparam logic [MODE_W-1:0] MODE_EVT_ON = 2'b11;

  typedef enum logic [1:0] {
    REG_CMP1  = 2'd0,
    REG_CMP2  = 2'd1,
    REG_CNT   = 2'd2,
    REG_SETUP = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/mft_prescaler.sv
module mft_prescaler #(
  parameter int MAX_SCALE = 8,
  parameter int SCALE_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               restart,
  input  logic               ref_tick,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);

  localparam int PRE_W = (MAX_SCALE > 0) ? MAX_SCALE : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  int               eff;

  always_comb begin
    eff = (int'(scale) > MAX_SCALE) ? MAX_SCALE : int'(scale);
    for (int b = 0; b < PRE_W; b++) begin
      mask[b] = (b < eff);
    end
  end

  assign tick = run && ref_tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pre_q <= '0;
    end else if (ref_tick) begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/mft_timer.sv
module mft_timer
  import mft_pkg::*;
#(
  parameter int DW        = 16,
  parameter int MAX_SCALE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmp1_o,
  output logic [DW-1:0] cmp2_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] setup_o,
  output logic          evt_o,
  output logic          en_o,
  output logic          f2_o,
  output logic          done_o
);

  logic [DW-1:0]      cmp1_q, cmp2_q, cnt_q;
  logic [SCALE_W-1:0] scale_q, scale_n;
  logic [MODE_W-1:0]  mode_q, mode_n;
  logic               en_q, en_n, f1_q, f1_n, f2_q, f2_n, done_q, done_n;
  logic               evt_q;
  logic               wr_cmp1, wr_cmp2, wr_cnt, wr_setup;
  logic               tick, step;
  logic [DW-1:0]      cnt_next;
  logic               hit1, hit2;

  assign wr_cmp1  = wr_en && (sel == REG_CMP1);
  assign wr_cmp2  = wr_en && (sel == REG_CMP2);
  assign wr_cnt   = wr_en && (sel == REG_CNT);
  assign wr_setup = wr_en && (sel == REG_SETUP);

  mft_prescaler #(
    .MAX_SCALE(MAX_SCALE),
    .SCALE_W  (SCALE_W)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (en_q),
    .restart (wr_cnt),
    .ref_tick(ref_tick),
    .scale   (scale_q),
    .tick    (tick)
  );

  assign step     = tick && !wr_cnt;
  assign cnt_next = (cnt_q == cmp2_q) ? '0 : cnt_q + 1'b1;
  assign hit1     = step && (cnt_next == cmp1_q);
  assign hit2     = step && (cnt_next == cmp2_q);

  always_comb begin
    done_n  = done_q | wr_setup;
    scale_n = scale_q;
    mode_n  = mode_q;
    en_n    = en_q;
    f1_n    = f1_q;
    f2_n    = f2_q;
    if (wr_setup) begin
      en_n = wdata[EN_BIT];
      if (!done_q) begin
        scale_n = wdata[SCALE_LSB +: SCALE_W];
        mode_n  = wdata[MODE_LSB +: MODE_W];
      end
      if (wdata[F1_BIT]) f1_n = 1'b0;
      if (wdata[F2_BIT]) f2_n = 1'b0;
    end
    if (hit1) f1_n = 1'b1;
    if (hit2) f2_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp1_q  <= '0;
      cmp2_q  <= '0;
      cnt_q   <= '0;
      scale_q <= '0;
      mode_q  <= '0;
      en_q    <= 1'b0;
      f1_q    <= 1'b0;
      f2_q    <= 1'b0;
      done_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (wr_cmp1) cmp1_q <= wdata;
      if (wr_cmp2) cmp2_q <= wdata;
      if (wr_cnt) begin
        cnt_q <= wdata;
      end else if (step) begin
        cnt_q <= cnt_next;
      end
      scale_q <= scale_n;
      mode_q  <= mode_n;
      en_q    <= en_n;
      f1_q    <= f1_n;
      f2_q    <= f2_n;
      done_q  <= done_n;
      evt_q   <= f2_n && (mode_n == MODE_EVT_ON);
    end
  end

  always_comb begin
    setup_o = '0;
    setup_o[SCALE_LSB +: SCALE_W] = scale_q;
    setup_o[MODE_LSB +: MODE_W]   = mode_q;
    setup_o[DONE_BIT] = done_q;
    setup_o[F1_BIT]   = f1_q;
    setup_o[F2_BIT]   = f2_q;
    setup_o[EN_BIT]   = en_q;
  end

  assign cmp1_o = cmp1_q;
  assign cmp2_o = cmp2_q;
  assign cnt_o  = cnt_q;
  assign evt_o  = evt_q;
  assign en_o   = en_q;
  assign f2_o   = f2_q;
  assign done_o = done_q;

  logic wdata_unused;
  assign wdata_unused = ^{wdata[7:4], wdata[11:10], wdata[DONE_BIT]};

endmodule

// File: rtl/mft_bank.sv
module mft_bank
  import mft_pkg::*;
#(
  parameter int N_TIMERS  = 8,
  parameter int ADDR_W    = 8,
  parameter int DW        = 16,
  parameter int MAX_SCALE = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_tick,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic [N_TIMERS-1:0] evt_out
);

  localparam int WIN_BYTES = N_TIMERS * 8;
  localparam int IDX_W     = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1;

  logic              in_win;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        sel;
  logic [DW-1:0]     words [N_TIMERS][4];
  logic [DW-1:0]     rdata_q;

  logic [N_TIMERS-1:0]    en_vec, f2_vec, done_vec;
  logic [N_TIMERS*DW-1:0] cnt_flat;

  assign in_win = (32'(addr) < WIN_BYTES);
  assign idx    = addr[3 +: IDX_W];
  assign sel    = addr[2:1];

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    logic          wr_i;
    logic [DW-1:0] c1, c2, cn, su;

    assign wr_i = wr_en && in_win && (32'(idx) == i);

    mft_timer #(
      .DW       (DW),
      .MAX_SCALE(MAX_SCALE)
    ) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .ref_tick(ref_tick),
      .wr_en   (wr_i),
      .sel     (sel),
      .wdata   (wdata),
      .cmp1_o  (c1),
      .cmp2_o  (c2),
      .cnt_o   (cn),
      .setup_o (su),
      .evt_o   (evt_out[i]),
      .en_o    (en_vec[i]),
      .f2_o    (f2_vec[i]),
      .done_o  (done_vec[i])
    );

    assign words[i][0] = c1;
    assign words[i][1] = c2;
    assign words[i][2] = cn;
    assign words[i][3] = su;
    assign cnt_flat[i*DW +: DW] = cn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= in_win ? words[idx][sel] : '0;
    end
  end

  assign rdata = rdata_q;

  logic addr_unused;
  assign addr_unused = addr[0];

endmodule

// File: rtl/mft_bank_chk.sv
module mft_bank_chk #(
  parameter int N_TIMERS = 8,
  parameter int ADDR_W   = 8,
  parameter int DW       = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [ADDR_W-1:0]      addr,
  input logic [DW-1:0]          rdata,
  input logic [N_TIMERS-1:0]    evt_out,
  input logic [N_TIMERS-1:0]    en_vec,
  input logic [N_TIMERS-1:0]    f2_vec,
  input logic [N_TIMERS-1:0]    done_vec,
  input logic [N_TIMERS*DW-1:0] cnt_flat
);

  logic miss;
  assign miss = (32'(addr) >= N_TIMERS * 8);

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && miss) |=> (rdata == '0)); // R3

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
    AST_EVT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
      evt_out[i] |-> f2_vec[i]); // R9

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
      done_vec[i] |=> done_vec[i]); // R11

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      (!en_vec[i] && !wr_en) |=> $stable(cnt_flat[i*DW +: DW])); // R6

    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
      $fell(f2_vec[i]) |-> $past(wr_en)); // R10
  end

endmodule

bind mft_bank mft_bank_chk #(
  .N_TIMERS(N_TIMERS),
  .ADDR_W  (ADDR_W),
  .DW      (DW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .evt_out (evt_out),
  .en_vec  (en_vec),
  .f2_vec  (f2_vec),
  .done_vec(done_vec),
  .cnt_flat(cnt_flat)
);

// File: tb/mft_bank_tb.sv
`timescale 1ns/1ps
module mft_bank_tb;

  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_tick = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  evt_out;

  int total = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mft_bank #(.N_TIMERS(N), .ADDR_W(AW), .DW(DW), .MAX_SCALE(8)) u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt_out(evt_out)
  );

  // setup word: [15] en, [14] clear f2, [13] clear f1, [9:8] mode, [3:0] exponent
  function automatic logic [15:0] mk(input bit en, input bit c2, input bit c1,
                                     input logic [1:0] mode, input logic [3:0] sc);
    return {en, c2, c1, 1'b0, 2'b00, mode, 4'b0000, sc};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; ref_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; failed++;
        $display("FAIL watchdog got=%0d exp=<100000", cyc);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    do_reset();

    // R1: reset state
    for (int t = 0; t < N; t++) begin
      for (int r = 0; r < 4; r++) begin
        rd(t*8 + r*2, v);
        chk("R1 reset reg", v, 0);
      end
    end
    chk("R1 evt after reset", evt_out, 0);

    // R2: per-timer decode, bit 0 ignored
    for (int t = 0; t < N; t++) begin
      wr(t*8 + 0, 16'h1000 + 16'(t));
      wr(t*8 + 2, 16'h2000 + 16'(t));
      wr(t*8 + 4, 16'h3000 + 16'(t));
    end
    for (int t = 0; t < N; t++) begin
      rd(t*8 + 0, v); chk("R2 cmp1", v, 16'h1000 + 16'(t));
      rd(t*8 + 3, v); chk("R2 cmp2 odd addr", v, 16'h2000 + 16'(t));
      rd(t*8 + 4, v); chk("R2 counter", v, 16'h3000 + 16'(t));
    end

    // R3: outside window
    wr(8'h22, 16'hBEEF);
    rd(8'h22, v); chk("R3 miss reads zero", v, 0);
    rd(8'h3E, v); chk("R3 miss high", v, 0);
    rd(8'h02, v); chk("R3 no alias write", v, 16'h2000);

    // R7/R8/R9/R4: single-stepped timer 1
    do_reset();
    wr(8 + 0, 16'd1);
    wr(8 + 2, 16'd2);
    wr(8 + 6, mk(1, 0, 0, 2'b11, 4'd0));
    pulse();
    rd(8 + 4, v); chk("R6 step 1", v, 1);
    rd(8 + 6, v); chk("R8 R4 cmp1 flag", v, 16'hB300);
    chk("R8 no evt from cmp1", evt_out[1], 0);
    pulse();
    rd(8 + 4, v); chk("R7 reach cmp2", v, 2);
    chk("R9 evt on cmp2", evt_out[1], 1);
    pulse();
    rd(8 + 4, v); chk("R7 wrap to 0", v, 0);
    chk("R9 evt sticky", evt_out[1], 1);

    // R10: write-one-to-clear
    wr(8 + 6, mk(1, 0, 1, 2'b00, 4'd0));
    rd(8 + 6, v); chk("R10 clear f1 only", v, 16'hD300);
    chk("R10 evt kept", evt_out[1], 1);
    wr(8 + 6, mk(0, 1, 1, 2'b00, 4'd0));
    chk("R10 evt dropped", evt_out[1], 0);
    rd(8 + 6, v); chk("R10 stop and ack", v, 16'h1300);
    pulse();
    rd(8 + 4, v); chk("R6 hold when off", v, 0);

    // R11: lock
    wr(8 + 6, mk(1, 0, 0, 2'b00, 4'd5));
    rd(8 + 6, v); chk("R11 fields locked", v, 16'h9300);
    pulse();
    rd(8 + 4, v); chk("R11 scale still 1", v, 1);

    // R12/R13/R9: timer 2, mode 0
    wr(16 + 0, 16'd0);
    wr(16 + 2, 16'h0010);
    wr(16 + 4, 16'hFFFF);
    wr(16 + 6, mk(1, 0, 0, 2'b00, 4'd0));
    rd(16 + 6, v); chk("R12 write sets no flag", v, 16'h9000);
    pulse();
    rd(16 + 4, v); chk("R13 rollover", v, 0);
    rd(16 + 6, v); chk("R13 cmp1 at zero", v, 16'hB000);
    for (int k = 0; k < 16; k++) pulse();
    rd(16 + 4, v); chk("R7 timer2 cmp2", v, 16'h0010);
    rd(16 + 6, v); chk("R9 f2 flag mode0", v, 16'hF000);
    chk("R9 no evt mode0", evt_out[2], 0);
    wr(16 + 4, 16'd0);
    rd(16 + 4, v); chk("R12 write zero", v, 0);

    // R5: exponent sweep with strobe held high
    for (int s = 0; s < 10; s++) begin
      int n;
      int exp_n;
      do_reset();
      wr(24 + 2, 16'd3);
      @(negedge clk);
      ref_tick = 1'b1;
      wr(24 + 6, mk(1, 0, 0, 2'b11, 4'(s)));
      n = 0;
      while (n < 2000) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        if (evt_out[3]) break;
      end
      ref_tick = 1'b0;
      exp_n = 3 * (1 << ((s > 8) ? 8 : s));
      chk($sformatf("R5 divisor exp %0d", s), n, exp_n);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule